// File: doc/BRIEF.md
# Millisecond Real-Time Counter with Coherent Seconds Capture

This block keeps wall-clock time as a pair of counters, a seconds count and a sub-second count in milliseconds, both advanced by a one-cycle tick pulse that arrives at 1 kHz. Seconds times one thousand plus milliseconds gives the full timestamp, so the millisecond field stays between 0 and 999. The block has no enable and no sleep input: it counts for as long as it is clocked and out of reset, including while the rest of the system is suspended.

Two separate reads cannot sample a moving pair of counters coherently, because a second boundary may pass between them. To fix this, a read of the millisecond register also copies the live seconds value into a shadow register in the same clock edge. Software reads milliseconds first and then the shadow seconds, and the two values always belong to the same instant. The live seconds count can also be read directly, and written to set the time, which also restarts the millisecond field at zero.

Register offsets (byte addresses, word aligned): live seconds at 0x08 (read/write), shadow seconds at 0x0C (read only), milliseconds at 0x10 (read only). Every other offset reads as zero and ignores writes.

Top module: `rtc_ms_shadow`

## Requirements
- R1: After reset the seconds count, the millisecond count and the shadow register are all zero, and rd_valid_o is low.
- R2: Each tick pulse with the millisecond count below 999 raises it by exactly one; with no tick and no seconds write, both counters hold their values.
- R3: A tick with the millisecond count at 999 sets it to 0 and raises the seconds count by one at the same clock edge; the millisecond count never exceeds 999.
- R4: The seconds count wraps from 0xFFFFFFFF to 0 on a carry.
- R5: A read of offset 0x10 returns the millisecond count and, at the same edge, copies the live seconds count into the shadow register, which a read of offset 0x0C then returns.
- R6: The shadow register changes only on a read of offset 0x10; reads of 0x08 and 0x0C, writes, and ticks leave it untouched, while a read of 0x08 returns the live seconds count.
- R7: A write to offset 0x08 loads wdata_i into the seconds count and clears the millisecond count; it takes precedence over a tick in the same cycle.
- R8: Writes to offsets 0x0C, 0x10 and all unmapped offsets change no counter and no shadow value.
- R9: A read of any offset other than 0x08, 0x0C and 0x10 returns zero.
- R10: Read data appears on rdata_o with rd_valid_o high in the cycle after rd_en_i is sampled, for exactly one cycle per read.
- R11: When a tick coincides with a millisecond read, the read returns the value before the tick and the shadow captures the seconds value before the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle pulse at 1 kHz |
| rd_en_i | input | 1 | Read request for addr_i |
| wr_en_i | input | 1 | Write request for addr_i |
| addr_i | input | ADDR_W (8) | Byte offset of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, valid with rd_valid_o |
| rd_valid_o | output | 1 | Read data valid, one cycle after the request |

## Verification
The assertions assume tick_i is a synchronous pulse sampled once per clock, and that read and write requests are never raised in the same cycle, since a combined access has no defined ordering between the shadow capture and the seconds load. The stimulus issues one bus operation per cycle, drives ticks as isolated or back-to-back single-cycle pulses, and only combines a tick with a single read or a single write, which is exactly where the coincident-event requirements are exercised.

// File: rtl/rtc_ms_pkg.sv
package rtc_ms_pkg;

   // Byte offsets decoded by software; their values are part of the contract.
   localparam int unsigned OFS_LIVE_SEC   = 32'h08;
   localparam int unsigned OFS_SHADOW_SEC = 32'h0C;
   localparam int unsigned OFS_MSEC       = 32'h10;

   // Highest offset decoded, used to check the address width.
   localparam int unsigned OFS_TOP        = OFS_MSEC;

   typedef enum logic [1:0] {
      SEL_NONE   = 2'd0,
      SEL_LIVE   = 2'd1,
      SEL_SHADOW = 2'd2,
      SEL_MSEC   = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/rtc_msec_counter.sv
module rtc_msec_counter #(
   parameter int unsigned MS_PER_SEC = 1000,
   parameter int unsigned MS_W       = $clog2(MS_PER_SEC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            clear_i,
   output logic [MS_W-1:0] ms_o,
   output logic            carry_o
);

   localparam logic [MS_W-1:0] MS_LAST = MS_W'(MS_PER_SEC - 1);

   logic [MS_W-1:0] ms_q;
   logic            at_last;

   assign at_last = (ms_q == MS_LAST);
   // A seconds load discards the carry of a coincident tick.
   assign carry_o = tick_i && at_last && !clear_i;
   assign ms_o    = ms_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ms_q <= '0;
      end else if (clear_i) begin
         ms_q <= '0;
      end else if (tick_i) begin
         if (at_last) ms_q <= '0;
         else         ms_q <= ms_q + 1'b1;
      end
   end

   assert_ms_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ms_q <= MS_LAST);

   assert_ms_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !clear_i && !at_last) |=> (ms_q == $past(ms_q) + 1'b1));

   assert_ms_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !clear_i) |=> $stable(ms_q));

   assert_ms_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      carry_o |=> (ms_q == '0));

   assert_ms_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clear_i |=> (ms_q == '0));

endmodule

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
   parameter int unsigned SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             load_i,
   input  logic [SEC_W-1:0] load_val_i,
   output logic [SEC_W-1:0] sec_o
);

   logic [SEC_W-1:0] sec_q;

   assign sec_o = sec_q;

   always_ff @(posedge clk) begin
      if (!rst_n)      sec_q <= '0;
      else if (load_i) sec_q <= load_val_i;
      else if (inc_i)  sec_q <= sec_q + 1'b1;
   end

   assert_sec_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (sec_q == $past(load_val_i)));

   // Modular increment covers the all-ones to zero wrap.
   assert_sec_inc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && !load_i) |=> (sec_q == $past(sec_q) + 1'b1));

   assert_sec_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !load_i) |=> $stable(sec_q));

endmodule

// File: rtl/rtc_shadow_reg.sv
module rtc_shadow_reg #(
   parameter int unsigned SEC_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             capture_i,
   input  logic [SEC_W-1:0] sec_i,
   output logic [SEC_W-1:0] shadow_o
);

   logic [SEC_W-1:0] shadow_q;

   assign shadow_o = shadow_q;

   always_ff @(posedge clk) begin
      if (!rst_n)         shadow_q <= '0;
      else if (capture_i) shadow_q <= sec_i;
   end

   assert_shadow_take_R5: assert property (@(posedge clk) disable iff (!rst_n)
      capture_i |=> (shadow_q == $past(sec_i)));

   assert_shadow_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !capture_i |=> $stable(shadow_q));

endmodule

// File: rtl/rtc_reg_decode.sv
module rtc_reg_decode
   import rtc_ms_pkg::*;
#(
   parameter int unsigned ADDR_W   = 8,
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned SEC_W    = 32,
   parameter int unsigned MS_W     = 10,
   parameter bit          READ_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [SEC_W-1:0]  live_sec_i,
   input  logic [SEC_W-1:0]  shadow_sec_i,
   input  logic [MS_W-1:0]   ms_i,
   output logic              load_sec_o,
   output logic              capture_o,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rd_valid_o
);

   localparam logic [ADDR_W-1:0] A_LIVE   = ADDR_W'(OFS_LIVE_SEC);
   localparam logic [ADDR_W-1:0] A_SHADOW = ADDR_W'(OFS_SHADOW_SEC);
   localparam logic [ADDR_W-1:0] A_MSEC   = ADDR_W'(OFS_MSEC);

   reg_sel_e          sel;
   logic [DATA_W-1:0] rd_mux;

   always_comb begin
      if      (addr_i == A_LIVE)   sel = SEL_LIVE;
      else if (addr_i == A_SHADOW) sel = SEL_SHADOW;
      else if (addr_i == A_MSEC)   sel = SEL_MSEC;
      else                         sel = SEL_NONE;
   end

   // Only the live seconds register accepts writes.
   assign load_sec_o = wr_en_i && (sel == SEL_LIVE);
   // Reading milliseconds freezes the seconds that belong with it.
   assign capture_o  = rd_en_i && (sel == SEL_MSEC);

   always_comb begin
      case (sel)
         SEL_LIVE:   rd_mux = DATA_W'(live_sec_i);
         SEL_SHADOW: rd_mux = DATA_W'(shadow_sec_i);
         SEL_MSEC:   rd_mux = DATA_W'(ms_i);
         default:    rd_mux = '0;
      endcase
   end

   generate
      if (READ_REG) begin : g_rd_flop
         logic [DATA_W-1:0] rdata_q;
         logic              valid_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               rdata_q <= '0;
               valid_q <= 1'b0;
            end else begin
               valid_q <= rd_en_i;
               rdata_q <= rd_en_i ? rd_mux : '0;
            end
         end

         assign rdata_o    = rdata_q;
         assign rd_valid_o = valid_q;

         assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
            rd_en_i |=> rd_valid_o);

         assert_rd_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_en_i |=> !rd_valid_o);
      end else begin : g_rd_comb
         assign rdata_o    = rd_en_i ? rd_mux : '0;
         assign rd_valid_o = rd_en_i;
      end
   endgenerate

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_NONE) |-> (rd_mux == '0));

   assert_no_combined_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_en_i && wr_en_i));

endmodule

// File: rtl/rtc_ms_shadow.sv
module rtc_ms_shadow
   import rtc_ms_pkg::*;
#(
   parameter int unsigned ADDR_W     = 8,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned SEC_W      = 32,
   parameter int unsigned MS_PER_SEC = 1000,
   parameter bit          READ_REG   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              rd_en_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic              rd_valid_o
);

   localparam int unsigned MS_W = $clog2(MS_PER_SEC);

   initial begin : param_checks
      assert (MS_PER_SEC >= 2)
         else $error("MS_PER_SEC must be at least 2");
      assert (SEC_W <= DATA_W)
         else $error("SEC_W must fit in DATA_W");
      assert (MS_W <= DATA_W)
         else $error("millisecond field must fit in DATA_W");
      assert ((64'd1 << ADDR_W) > 64'(OFS_TOP))
         else $error("ADDR_W too narrow for the register offsets");
   end

   logic [MS_W-1:0]  ms_val;
   logic [SEC_W-1:0] live_sec;
   logic [SEC_W-1:0] shadow_sec;
   logic             carry;
   logic             load_sec;
   logic             capture;

   rtc_reg_decode #(
      .ADDR_W   (ADDR_W),
      .DATA_W   (DATA_W),
      .SEC_W    (SEC_W),
      .MS_W     (MS_W),
      .READ_REG (READ_REG)
   ) decode_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .rd_en_i      (rd_en_i),
      .wr_en_i      (wr_en_i),
      .addr_i       (addr_i),
      .live_sec_i   (live_sec),
      .shadow_sec_i (shadow_sec),
      .ms_i         (ms_val),
      .load_sec_o   (load_sec),
      .capture_o    (capture),
      .rdata_o      (rdata_o),
      .rd_valid_o   (rd_valid_o)
   );

   rtc_msec_counter #(
      .MS_PER_SEC (MS_PER_SEC),
      .MS_W       (MS_W)
   ) msec_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .clear_i (load_sec),
      .ms_o    (ms_val),
      .carry_o (carry)
   );

   rtc_sec_counter #(
      .SEC_W (SEC_W)
   ) sec_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (carry),
      .load_i     (load_sec),
      .load_val_i (wdata_i[SEC_W-1:0]),
      .sec_o      (live_sec)
   );

   rtc_shadow_reg #(
      .SEC_W (SEC_W)
   ) shadow_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .capture_i (capture),
      .sec_i     (live_sec),
      .shadow_o  (shadow_sec)
   );

   // Carry into seconds happens exactly when milliseconds fold back to zero.
   assert_carry_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_i && !load_sec && ms_val == MS_W'(MS_PER_SEC - 1))
         |=> (ms_val == '0 && live_sec == $past(live_sec) + 1'b1));

   assert_pair_capture_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_i && addr_i == ADDR_W'(OFS_MSEC)) |=> (shadow_sec == $past(live_sec)));

endmodule

// File: tb/rtc_ms_shadow_tb.sv
module rtc_ms_shadow_tb_top;

   localparam int unsigned MS_LAST = 999;
   localparam int unsigned WD_LIMIT = 150000;

   typedef struct {
      logic [31:0] data;
      string       tag;
   } exp_item_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        rd_en_i = 1'b0;
   logic        wr_en_i = 1'b0;
   logic [7:0]  addr_i = '0;
   logic [31:0] wdata_i = '0;
   logic [31:0] rdata_o;
   logic        rd_valid_o;

   int unsigned n_vec = 0;
   int unsigned n_bad = 0;
   int unsigned cyc = 0;
   bit          done = 1'b0;

   exp_item_t   exp_q[$];

   // Reference state, built only from the requirements.
   logic [31:0] m_sec = '0;
   logic [31:0] m_ms = '0;
   logic [31:0] m_shadow = '0;

   always #5 clk = ~clk;

   rtc_ms_shadow dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick_i     (tick_i),
      .rd_en_i    (rd_en_i),
      .wr_en_i    (wr_en_i),
      .addr_i     (addr_i),
      .wdata_i    (wdata_i),
      .rdata_o    (rdata_o),
      .rd_valid_o (rd_valid_o)
   );

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
      end
   endtask

   function automatic logic [31:0] model_read(input logic [7:0] a);
      case (a)
         8'h08:   return m_sec;
         8'h0C:   return m_shadow;
         8'h10:   return m_ms;
         default: return 32'h0;
      endcase
   endfunction

   // One bus cycle; called at a falling edge, returns at the next falling edge.
   task automatic step(input logic tk, input logic rd, input logic wr,
                       input logic [7:0] a, input logic [31:0] wd, input string tag);
      exp_item_t it;
      tick_i  = tk;
      rd_en_i = rd;
      wr_en_i = wr;
      addr_i  = a;
      wdata_i = wd;
      if (rd) begin
         it.data = model_read(a);
         it.tag  = tag;
         exp_q.push_back(it);
         if (a == 8'h10) m_shadow = m_sec;
      end
      if (wr && a == 8'h08) begin
         m_sec = wd;
         m_ms  = 0;
      end else if (tk) begin
         if (m_ms == MS_LAST) begin
            m_ms  = 0;
            m_sec = m_sec + 1;
         end else begin
            m_ms = m_ms + 1;
         end
      end
      @(posedge clk);
      @(negedge clk);
      tick_i  = 1'b0;
      rd_en_i = 1'b0;
      wr_en_i = 1'b0;
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 32'h0, "tick");
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 8'h00, 32'h0, "idle");
   endtask

   task automatic rd(input logic [7:0] a, input string tag);
      step(1'b0, 1'b1, 1'b0, a, 32'h0, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
      step(1'b0, 1'b0, 1'b1, a, d, tag);
   endtask

   // Monitor: compares each returned read with the oldest expectation.
   always @(negedge clk) begin
      if (rst_n && rd_valid_o) begin
         if (exp_q.size() == 0) begin
            n_vec++;
            n_bad++;
            $display("FAIL R10: got unexpected rd_valid_o expected none pending");
         end else begin
            exp_item_t it;
            it = exp_q.pop_front();
            check(it.tag, rdata_o, it.data);
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > WD_LIMIT && !done) begin
         done = 1'b1;
         n_vec++;
         n_bad++;
         $display("FAIL watchdog: got %0d cycles expected below %0d", cyc, WD_LIMIT);
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 rd_valid in reset", {31'h0, rd_valid_o}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 rd_valid after reset", {31'h0, rd_valid_o}, 32'h0);

      // R1: everything reads zero out of reset
      rd(8'h08, "R1 live seconds");
      rd(8'h0C, "R1 shadow");
      rd(8'h10, "R1 milliseconds");

      // R2: plain ticks and idle holding
      ticks(5);
      rd(8'h10, "R2 five ticks");
      idle(4);
      rd(8'h10, "R2 hold without tick");
      rd(8'h08, "R2 seconds unchanged");

      // R7: load seconds clears milliseconds
      wr(8'h08, 32'd100, "R7 load");
      rd(8'h10, "R7 ms cleared");
      rd(8'h08, "R7 seconds loaded");

      // R3: rollover at 999
      ticks(999);
      rd(8'h10, "R3 ms at 999");
      rd(8'h0C, "R5 shadow 100");
      ticks(1);
      rd(8'h10, "R3 ms folded to 0");
      rd(8'h08, "R3 seconds carried");

      // R4: seconds wrap
      wr(8'h08, 32'hFFFF_FFFF, "R4 load all ones");
      ticks(1000);
      rd(8'h08, "R4 seconds wrapped");
      rd(8'h10, "R4 ms zero");

      // R5 / R6: shadow capture and hold across a boundary
      wr(8'h08, 32'd50, "R6 load");
      ticks(990);
      rd(8'h10, "R5 ms before boundary");
      ticks(20);
      rd(8'h08, "R6 live advanced");
      rd(8'h0C, "R5 shadow kept 50");
      wr(8'h0C, 32'd77, "R8 write shadow");
      rd(8'h0C, "R8 shadow write ignored");
      rd(8'h08, "R6 live read");
      rd(8'h0C, "R6 shadow after live read");
      rd(8'h10, "R6 ms still counting");

      // R11: tick in the same cycle as a millisecond read
      wr(8'h08, 32'd7, "R11 load");
      ticks(999);
      step(1'b1, 1'b1, 1'b0, 8'h10, 32'h0, "R11 ms read pre-tick");
      rd(8'h0C, "R11 shadow pre-tick");
      rd(8'h08, "R11 seconds after carry");
      rd(8'h10, "R11 ms after carry");

      // R7: write wins over coincident tick
      ticks(3);
      step(1'b1, 1'b0, 1'b1, 8'h08, 32'd20, "R7 write with tick");
      rd(8'h10, "R7 ms zero over tick");
      rd(8'h08, "R7 seconds loaded over tick");

      // R8 / R9: ignored writes, unmapped reads
      ticks(6);
      wr(8'h10, 32'd5, "R8 write ms");
      wr(8'h04, 32'hDEAD_BEEF, "R8 write unmapped");
      rd(8'h10, "R8 ms unchanged");
      rd(8'h08, "R8 seconds unchanged");
      rd(8'h04, "R9 offset 0x04");
      rd(8'h14, "R9 offset 0x14");
      rd(8'h09, "R9 offset 0x09");

      idle(3);
      n_vec++;
      if (exp_q.size() != 0) begin
         n_bad++;
         $display("FAIL R10: got %0d reads outstanding expected 0", exp_q.size());
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule